// File: doc/BRIEF.md
# Interrupt Source Masking and Routing Controller

This block gathers a set of interrupt sources and turns them into two requests for a processor: a normal request and a fast request. Each source is the OR of an external hardware line and a software-raised bit. Every source has an enable bit and a route bit that steers it to the fast path or to the normal path. A source on the fast path reaches the fast request without passing through its enable bit. A source on the normal path needs its enable bit set.

Software reaches the state through a small register port that uses word offsets. Reads are combinational and are valid in the cycle the address is presented. Writes take effect at the clock edge. The enable bits and the software bits each have one address that sets bits and another that clears them, so a single bit changes without a read-modify-write. A priority gate vector arrives from the vector logic outside this block. It restricts which normal-path sources may raise the normal request. Both requests leave the block through a register.

Top module: `irq_route_ctrl`

## Requirements
- R1: A read at word offset 2 returns the raw source vector, which is the bitwise OR of `hw_lines` and the software bits.
- R2: A read at word offset 0 returns the normal status, which is raw AND enable AND NOT route.
- R3: A read at word offset 1 returns the fast status, which is raw AND route. The enable bits have no effect on it.
- R4: A write to offset 4 ORs the written value into the enable bits. A read at offset 4 returns the enable bits.
- R5: A write to offset 5 clears each enable bit whose written bit is 1 and leaves the other enable bits as they were.
- R6: A write to offset 6 ORs the written value into the software bits. A write to offset 7 clears each software bit whose written bit is 1. A read at offset 6 returns the software bits.
- R7: A write to offset 3 replaces the whole route vector, where 1 selects the fast path. A read at offset 3 returns the route vector.
- R8: A write to offset 8 stores only bit 0 of the written value as the protection bit. A read at offset 8 returns that bit in bit 0 and zero in every other bit.
- R9: Writes to offsets 0, 1, 2 and 9 to 15 change no state. Reads at offsets 5, 7 and 9 to 15 return zero.
- R10: `fiq_o` is 1 in the cycle after any cycle in which the fast status is nonzero, and 0 otherwise. A state change made at a clock edge therefore reaches `fiq_o` one edge later.
- R11: `irq_o` is 1 in the cycle after any cycle in which the normal status ANDed with `prio_gate` is nonzero, and 0 otherwise.
- R12: After reset, the enable, route, software and protection state are all zero, and `irq_o` and `fiq_o` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_lines | input | NSRC | Hardware interrupt line levels |
| prio_gate | input | NSRC | Sources allowed to raise the normal request, from the vector priority logic |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | AW | Word offset |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Registered normal interrupt request |
| fiq_o | output | 1 | Registered fast interrupt request |

## Verification
The bench goes after three cases: a source on the fast path whose enable bit is clear, a set/clear pair written in the same sequence, and a normal-path source that `prio_gate` blocks. A design that applied the enable bits to the fast path would never raise `fiq_o` in the bypass case. A design that treated the set or clear address as a plain store would wipe out unrelated bits, and the bench's model would flag them at the next readback. The bench also writes all ones to every read-only and undefined offset and then reads the whole map back. A decode that aliased those offsets onto real registers would corrupt state there. A final check samples `fiq_o` in the cycle right after the enabling write to expose a request that bypassed the output register.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  // Word offsets of the register port
  localparam int unsigned OFS_NSTAT    = 0;
  localparam int unsigned OFS_FSTAT    = 1;
  localparam int unsigned OFS_RAW      = 2;
  localparam int unsigned OFS_ROUTE    = 3;
  localparam int unsigned OFS_EN_SET   = 4;
  localparam int unsigned OFS_EN_CLR   = 5;
  localparam int unsigned OFS_SOFT_SET = 6;
  localparam int unsigned OFS_SOFT_CLR = 7;
  localparam int unsigned OFS_PROT     = 8;
endpackage

// File: rtl/irq_src_regs.sv
module irq_src_regs
  import irq_route_pkg::*;
#(
  parameter int NSRC = 32,
  parameter int DW   = 32,
  parameter int AW   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [DW-1:0]   wr_data,
  output logic [NSRC-1:0] en_q,
  output logic [NSRC-1:0] route_q,
  output logic [NSRC-1:0] soft_q,
  output logic            prot_q
);
  logic [NSRC-1:0] d;
  assign d = wr_data[NSRC-1:0];

  // Decoded write events, brought out by name for the checks below
  logic hit_route, hit_en_set, hit_en_clr, hit_soft_set, hit_soft_clr, hit_prot;
  logic hit_any;
  assign hit_route    = wr_en && (wr_addr == AW'(OFS_ROUTE));
  assign hit_en_set   = wr_en && (wr_addr == AW'(OFS_EN_SET));
  assign hit_en_clr   = wr_en && (wr_addr == AW'(OFS_EN_CLR));
  assign hit_soft_set = wr_en && (wr_addr == AW'(OFS_SOFT_SET));
  assign hit_soft_clr = wr_en && (wr_addr == AW'(OFS_SOFT_CLR));
  assign hit_prot     = wr_en && (wr_addr == AW'(OFS_PROT));
  assign hit_any = hit_route | hit_en_set | hit_en_clr | hit_soft_set |
                   hit_soft_clr | hit_prot;

  function automatic logic [NSRC-1:0] set_bits(input logic [NSRC-1:0] cur,
                                                input logic [NSRC-1:0] val);
    return cur | val;
  endfunction

  function automatic logic [NSRC-1:0] clr_bits(input logic [NSRC-1:0] cur,
                                                input logic [NSRC-1:0] val);
    return cur & ~val;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= '0;
      route_q <= '0;
      soft_q  <= '0;
      prot_q  <= 1'b0;
    end else begin
      if (hit_route)    route_q <= d;
      if (hit_en_set)   en_q    <= set_bits(en_q, d);
      if (hit_en_clr)   en_q    <= clr_bits(en_q, d);
      if (hit_soft_set) soft_q  <= set_bits(soft_q, d);
      if (hit_soft_clr) soft_q  <= clr_bits(soft_q, d);
      if (hit_prot)     prot_q  <= wr_data[0];
    end
  end

  // R4
  en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_en_set |=> ((en_q & $past(d)) == $past(d)) &&
                   ((en_q & $past(en_q)) == $past(en_q)));
  // R5
  en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_en_clr |=> ((en_q & $past(d)) == '0) &&
                   ((en_q & ~$past(en_q)) == '0));
  // R6
  soft_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_soft_set |=> ((soft_q & $past(d)) == $past(d)));
  // R6
  soft_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_soft_clr |=> ((soft_q & $past(d)) == '0));
  // R9
  ignored_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !hit_any) |=> $stable(en_q) && $stable(route_q) &&
                            $stable(soft_q) && $stable(prot_q));
endmodule

// File: rtl/irq_status_calc.sv
module irq_status_calc #(
  parameter int NSRC = 32
) (
  input  logic [NSRC-1:0] hw_lines,
  input  logic [NSRC-1:0] soft_q,
  input  logic [NSRC-1:0] en_q,
  input  logic [NSRC-1:0] route_q,
  output logic [NSRC-1:0] raw,
  output logic [NSRC-1:0] nstat,
  output logic [NSRC-1:0] fstat
);
  function automatic logic [NSRC-1:0] calc_raw(input logic [NSRC-1:0] h,
                                                input logic [NSRC-1:0] s);
    return h | s;
  endfunction

  function automatic logic [NSRC-1:0] calc_normal(input logic [NSRC-1:0] r,
                                                   input logic [NSRC-1:0] e,
                                                   input logic [NSRC-1:0] sel);
    return r & e & ~sel;
  endfunction

  function automatic logic [NSRC-1:0] calc_fast(input logic [NSRC-1:0] r,
                                                 input logic [NSRC-1:0] sel);
    return r & sel;
  endfunction

  assign raw   = calc_raw(hw_lines, soft_q);
  assign nstat = calc_normal(raw, en_q, route_q);
  assign fstat = calc_fast(raw, route_q);
endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux
  import irq_route_pkg::*;
#(
  parameter int NSRC = 32,
  parameter int DW   = 32,
  parameter int AW   = 4
) (
  input  logic [AW-1:0]   rd_addr,
  input  logic [NSRC-1:0] raw,
  input  logic [NSRC-1:0] nstat,
  input  logic [NSRC-1:0] fstat,
  input  logic [NSRC-1:0] route_q,
  input  logic [NSRC-1:0] en_q,
  input  logic [NSRC-1:0] soft_q,
  input  logic            prot_q,
  output logic [DW-1:0]   rd_data
);
  function automatic logic [DW-1:0] widen(input logic [NSRC-1:0] v);
    return DW'(v);
  endfunction

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      AW'(OFS_NSTAT):    rd_data = widen(nstat);
      AW'(OFS_FSTAT):    rd_data = widen(fstat);
      AW'(OFS_RAW):      rd_data = widen(raw);
      AW'(OFS_ROUTE):    rd_data = widen(route_q);
      AW'(OFS_EN_SET):   rd_data = widen(en_q);
      AW'(OFS_SOFT_SET): rd_data = widen(soft_q);
      AW'(OFS_PROT):     rd_data = DW'(prot_q);
      default:           rd_data = '0;
    endcase
  end
endmodule

// File: rtl/irq_out_stage.sv
module irq_out_stage #(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] nstat,
  input  logic [NSRC-1:0] fstat,
  input  logic [NSRC-1:0] prio_gate,
  output logic            irq_o,
  output logic            fiq_o
);
  function automatic logic any_gated(input logic [NSRC-1:0] s,
                                     input logic [NSRC-1:0] g);
    return |(s & g);
  endfunction

  logic irq_next, fiq_next;
  assign irq_next = any_gated(nstat, prio_gate);
  assign fiq_next = |fstat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_o <= 1'b0;
      fiq_o <= 1'b0;
    end else begin
      irq_o <= irq_next;
      fiq_o <= fiq_next;
    end
  end

  // R10
  fiq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fstat != '0) |=> fiq_o);
  // R10
  fiq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fstat == '0) |=> !fiq_o);
  // R11
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((nstat & prio_gate) == '0) |=> !irq_o);
endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irq_route_pkg::*;
#(
  parameter int NSRC = 32,
  parameter int DW   = 32,
  parameter int AW   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] hw_lines,
  input  logic [NSRC-1:0] prio_gate,
  input  logic            bus_wr,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  output logic            irq_o,
  output logic            fiq_o
);
  logic [NSRC-1:0] en_q, route_q, soft_q;
  logic            prot_q;
  logic [NSRC-1:0] raw, nstat, fstat;

  irq_src_regs #(.NSRC(NSRC), .DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .wr_addr(bus_addr),
    .wr_data(bus_wdata), .en_q(en_q), .route_q(route_q), .soft_q(soft_q),
    .prot_q(prot_q)
  );

  irq_status_calc #(.NSRC(NSRC)) u_status (
    .hw_lines(hw_lines), .soft_q(soft_q), .en_q(en_q), .route_q(route_q),
    .raw(raw), .nstat(nstat), .fstat(fstat)
  );

  irq_read_mux #(.NSRC(NSRC), .DW(DW), .AW(AW)) u_rmux (
    .rd_addr(bus_addr), .raw(raw), .nstat(nstat), .fstat(fstat),
    .route_q(route_q), .en_q(en_q), .soft_q(soft_q), .prot_q(prot_q),
    .rd_data(bus_rdata)
  );

  irq_out_stage #(.NSRC(NSRC)) u_out (
    .clk(clk), .rst_n(rst_n), .nstat(nstat), .fstat(fstat),
    .prio_gate(prio_gate), .irq_o(irq_o), .fiq_o(fiq_o)
  );

  // R8
  prot_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == AW'(OFS_PROT)) |-> (bus_rdata[DW-1:1] == '0));
  // R3
  fast_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((raw & route_q & ~en_q) != '0) |-> (fstat != '0));
endmodule

// File: tb/irq_route_ctrl_test.sv
module irq_route_ctrl_test;
  localparam int NSRC = 32;
  localparam int DW   = 32;
  localparam int AW   = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NSRC-1:0] hw_lines = '0;
  logic [NSRC-1:0] prio_gate = '0;
  logic            bus_wr = 1'b0;
  logic [AW-1:0]   bus_addr = '0;
  logic [DW-1:0]   bus_wdata = '0;
  logic [DW-1:0]   bus_rdata;
  logic            irq_o, fiq_o;

  irq_route_ctrl #(.NSRC(NSRC), .DW(DW), .AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .hw_lines(hw_lines), .prio_gate(prio_gate),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_o(irq_o), .fiq_o(fiq_o)
  );

  always #4 clk = ~clk; // 125 MHz

  int checks = 0;
  int fails  = 0;
  logic [31:0] m_en = '0, m_route = '0, m_soft = '0;
  logic        m_prot = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] x);
    logic [31:0] y = x;
    y = y ^ (y << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  function automatic logic [31:0] exp_read(input int ofs);
    logic [31:0] raw;
    raw = hw_lines | m_soft;
    case (ofs)
      0: return raw & m_en & ~m_route;
      1: return raw & m_route;
      2: return raw;
      3: return m_route;
      4: return m_en;
      6: return m_soft;
      8: return {31'b0, m_prot};
      default: return 32'h0;
    endcase
  endfunction

  task automatic do_write(input int ofs, input logic [31:0] val);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = AW'(ofs); bus_wdata = val;
    @(negedge clk);
    bus_wr = 1'b0;
    case (ofs)
      3: m_route = val;
      4: m_en = m_en | val;
      5: m_en = m_en & ~val;
      6: m_soft = m_soft | val;
      7: m_soft = m_soft & ~val;
      8: m_prot = val[0];
      default: ;
    endcase
  endtask

  task automatic check_map(input string ctx);
    for (int o = 0; o < 16; o++) begin
      bus_addr = AW'(o);
      #1;
      case (o)
        0: chk({ctx, " R2 normal status"}, bus_rdata, exp_read(o));
        1: chk({ctx, " R3 fast status"}, bus_rdata, exp_read(o));
        2: chk({ctx, " R1 raw"}, bus_rdata, exp_read(o));
        3: chk({ctx, " R7 route"}, bus_rdata, exp_read(o));
        4: chk({ctx, " R4 enable"}, bus_rdata, exp_read(o));
        6: chk({ctx, " R6 soft"}, bus_rdata, exp_read(o));
        8: chk({ctx, " R8 prot"}, bus_rdata, exp_read(o));
        default: chk({ctx, " R9 zero read"}, bus_rdata, exp_read(o));
      endcase
    end
  endtask

  task automatic settle();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_outs(input string ctx);
    logic [31:0] ns, fs;
    ns = (hw_lines | m_soft) & m_en & ~m_route;
    fs = (hw_lines | m_soft) & m_route;
    chk({ctx, " R11 irq_o"}, {31'b0, irq_o}, {31'b0, |(ns & prio_gate)});
    chk({ctx, " R10 fiq_o"}, {31'b0, fiq_o}, {31'b0, |fs});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] r;
    r = 32'h1234_5678;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    check_map("R12 reset");
    chk("R12 irq_o after reset", {31'b0, irq_o}, 32'h0);
    chk("R12 fiq_o after reset", {31'b0, fiq_o}, 32'h0);

    // Sweep of patterns for R1..R7, R10, R11
    for (int i = 0; i < 48; i++) begin
      r = nxt(r); hw_lines = (i % 3 == 0) ? (32'h1 << (i % 32)) : r;
      r = nxt(r); prio_gate = (i % 4 == 0) ? 32'h0 : ((i % 4 == 1) ? 32'hFFFF_FFFF : r);
      r = nxt(r); do_write(4, r);
      r = nxt(r); do_write(5, r & 32'h0F0F_0F0F);
      r = nxt(r); do_write(3, (i % 2 == 0) ? (r & 32'h00FF_00FF) : 32'h0);
      r = nxt(r); do_write(6, r & 32'h3333_0000);
      r = nxt(r); do_write(7, r & 32'h1111_FFFF);
      check_map("sweep");
      settle();
      check_outs("sweep");
    end

    // R9: writes of all ones to read-only and undefined offsets
    for (int o = 0; o < 16; o++) begin
      if (o <= 2 || o >= 9) do_write(o, 32'hFFFF_FFFF);
    end
    check_map("R9 after ignored writes");

    // R8: only bit 0 stored
    do_write(8, 32'hFFFF_FFFE);
    bus_addr = AW'(8); #1;
    chk("R8 prot even value", bus_rdata, 32'h0);
    do_write(8, 32'h0000_0003);
    bus_addr = AW'(8); #1;
    chk("R8 prot odd value", bus_rdata, 32'h1);

    // Clean slate for directed output checks
    hw_lines = '0; prio_gate = '0;
    do_write(5, 32'hFFFF_FFFF);
    do_write(7, 32'hFFFF_FFFF);
    do_write(3, 32'h0);
    settle();
    chk("R10 fiq_o idle", {31'b0, fiq_o}, 32'h0);
    chk("R11 irq_o idle", {31'b0, irq_o}, 32'h0);

    // R3/R10: fast source with enable clear, one-cycle output latency
    do_write(6, 32'h0000_0020);
    do_write(3, 32'h0000_0020);
    chk("R10 fiq_o one edge after write still low", {31'b0, fiq_o}, 32'h0);
    settle();
    chk("R3 R10 fiq_o bypasses enable", {31'b0, fiq_o}, 32'h1);

    // R11: gate controls normal request
    do_write(3, 32'h0);
    do_write(4, 32'h0000_0020);
    settle();
    chk("R11 irq_o gated off", {31'b0, irq_o}, 32'h0);
    chk("R10 fiq_o after unroute", {31'b0, fiq_o}, 32'h0);
    prio_gate = 32'h0000_0020;
    settle();
    chk("R11 irq_o gate open", {31'b0, irq_o}, 32'h1);
    prio_gate = 32'h0000_0010;
    settle();
    chk("R11 irq_o other gate bit", {31'b0, irq_o}, 32'h0);

    // R5: clear of enable removes request
    prio_gate = 32'hFFFF_FFFF;
    do_write(5, 32'h0000_0020);
    settle();
    chk("R5 irq_o after enable clear", {31'b0, irq_o}, 32'h0);
    check_map("R5 final");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule